// File: doc/BRIEF.md
# CAN Transmit Buffer Status Flags

This block keeps the status flags for a CAN controller that has three transmit message buffers. Each buffer has an "empty" flag and an "abort acknowledged" flag. The CPU loads a message into a buffer and then clears that buffer's empty flag by writing a 1 to its bit. The protocol engine sets the flag again once the buffer is free. It reports that in one of two ways: with a pulse saying the message went out, or with a pulse saying it was dropped on request. After the empty flag comes back, software reads the acknowledge bit to learn which of the two happened.

The block also keeps a receiver-full flag and a register bit that enables its interrupt. Each transmit flag is combined with a per-flag enable input to form a registered transmit interrupt. A soft-reset input holds every flag, and the receive enable, at its reset value.

Top module: `cantx_flag_unit`

## Requirements
- R1: After hard reset, address 0 reads 0x07: empty flags in bits 2..0 read 1, acknowledge flags in bits 6..4 read 0, and bits 7 and 3 read 0. Addresses 1 and 2 read 0, and both interrupt outputs are 0.
- R2: A write to address 0 clears each flag whose bit in the write data is 1. A written 0 leaves that flag unchanged.
- R3: A sent pulse for buffer i sets empty flag i on the next clock. It leaves acknowledge flag i unchanged.
- R4: An aborted pulse for buffer i sets both empty flag i and acknowledge flag i on the next clock.
- R5: Acknowledge flag i is forced to 0 in any cycle where empty flag i becomes 0. It can also be cleared by writing 1 to bit 4+i.
- R6: If a pulse from the engine and a CPU clear hit the same flag in the same cycle, the flag ends up set.
- R7: The transmit interrupt output is registered. It is 1 exactly one clock after a cycle in which some flag was set while its enable input was high.
- R8: Address 1 bit 0 is the receiver-full flag. A receive pulse sets it, and writing 1 to that bit clears it. Address 2 bit 0 is the receive interrupt enable, which can be read and written. The receive interrupt output is 1 one clock after a cycle in which both bits were 1. With the enable at 0, it stays 0.
- R9: While the soft-reset input is 1, the flags are held at their reset values and the receive enable is held at 0. Writes to the enable are ignored.
- R10: Address 3 reads 0. Bits 7..1 of addresses 1 and 2 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst_i | input | 1 | Soft reset hold, active high |
| cpu_addr_i | input | 2 | Register select |
| cpu_wr_i | input | 1 | Write strobe |
| cpu_wdata_i | input | 8 | Write data |
| cpu_rdata_o | output | 8 | Read data for the selected register (combinational) |
| tx_sent_i | input | 3 | Per-buffer pulse: message transmitted |
| tx_aborted_i | input | 3 | Per-buffer pulse: message dropped on request |
| empty_ie_i | input | 3 | Interrupt enables for the empty flags |
| abort_ie_i | input | 3 | Interrupt enables for the acknowledge flags |
| rx_done_i | input | 1 | Pulse: a receive buffer was filled |
| tx_irq_o | output | 1 | Registered transmit interrupt |
| rx_irq_o | output | 1 | Registered receive interrupt |

## Verification
The assertions assume three things about the inputs. The engine pulses last one clock. The write strobe is sampled on the same edge as the pulses. The reset input is released synchronously enough that the first sampled cycle already reflects reset values.

The stimulus keeps to these rules. It changes every input just after a rising edge, and it drives each pulse for exactly one cycle. It also deliberately lines up pulses with CPU clears, and with soft reset, on the same edge. This exercises the precedence rules and the way a falling empty flag takes its acknowledge bit down with it.

// File: rtl/cantx_flag_pkg.sv
package cantx_flag_pkg;
    localparam int TXF_NBUF      = 3;
    localparam int TXF_DW        = 8;
    localparam int TXF_EMPTY_LSB = 0;
    localparam int TXF_ACK_LSB   = 4;
    localparam logic [1:0] ADDR_TXFLAG = 2'd0;
    localparam logic [1:0] ADDR_RXFLAG = 2'd1;
    localparam logic [1:0] ADDR_RXIE   = 2'd2;

    typedef struct packed {
        logic rx_full;
        logic rx_ie;
    } rx_state_t;

    typedef struct packed {
        logic empty;
        logic ack;
    } slot_state_t;
endpackage

// File: rtl/cantx_flag_slot.sv
module cantx_flag_slot
    import cantx_flag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_i,
    input  logic sent_i,
    input  logic abort_i,
    input  logic clr_empty_i,
    input  logic clr_ack_i,
    output logic empty_o,
    output logic ack_o
);
    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (soft_i) begin
            st_d.empty = 1'b1;
            st_d.ack   = 1'b0;
        end else begin
            st_d.empty = sent_i | abort_i | (st_q.empty & ~clr_empty_i);
            if (!st_d.empty)
                st_d.ack = 1'b0;
            else
                st_d.ack = abort_i | (st_q.ack & ~clr_ack_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.empty <= 1'b1;
            st_q.ack   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign empty_o = st_q.empty;
    assign ack_o   = st_q.ack;

    // R3
    sent_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sent_i |=> empty_o);
    // R4
    abort_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !soft_i) |=> (empty_o && ack_o));
    // R5
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && clr_empty_i && !sent_i && !abort_i && !soft_i) |=> !ack_o);
    // R2
    keep_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_empty_i && !soft_i) |=> (empty_o || !$past(empty_o)));
    // R6
    hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_empty_i && (sent_i || abort_i)) |=> empty_o);
endmodule

// File: rtl/cantx_irq_merge.sv
module cantx_irq_merge #(
    parameter int NBUF = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBUF-1:0] empty_i,
    input  logic [NBUF-1:0] ack_i,
    input  logic [NBUF-1:0] empty_ie_i,
    input  logic [NBUF-1:0] ack_ie_i,
    input  logic            rx_full_i,
    input  logic            rx_ie_i,
    output logic            tx_irq_o,
    output logic            rx_irq_o
);
    logic tx_d, tx_q, rx_d, rx_q;

    always_comb begin
        tx_d = (|(empty_i & empty_ie_i)) | (|(ack_i & ack_ie_i));
        rx_d = rx_full_i & rx_ie_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= 1'b0;
            rx_q <= 1'b0;
        end else begin
            tx_q <= tx_d;
            rx_q <= rx_d;
        end
    end

    assign tx_irq_o = tx_q;
    assign rx_irq_o = rx_q;

    // R7
    tx_irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((empty_i & empty_ie_i) != '0) |=> tx_irq_o);
    // R7
    tx_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((empty_i & empty_ie_i) == '0) && ((ack_i & ack_ie_i) == '0)) |=> !tx_irq_o);
    // R8
    rx_irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ie_i |=> !rx_irq_o);
endmodule

// File: rtl/cantx_flag_unit.sv
module cantx_flag_unit
    import cantx_flag_pkg::*;
#(
    parameter int NBUF = TXF_NBUF,
    parameter int AW   = 2,
    parameter int DW   = TXF_DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst_i,
    input  logic [AW-1:0]   cpu_addr_i,
    input  logic            cpu_wr_i,
    input  logic [DW-1:0]   cpu_wdata_i,
    output logic [DW-1:0]   cpu_rdata_o,
    input  logic [NBUF-1:0] tx_sent_i,
    input  logic [NBUF-1:0] tx_aborted_i,
    input  logic [NBUF-1:0] empty_ie_i,
    input  logic [NBUF-1:0] abort_ie_i,
    input  logic            rx_done_i,
    output logic            tx_irq_o,
    output logic            rx_irq_o
);
    localparam int ADDR_TX = int'(ADDR_TXFLAG);
    localparam int ADDR_RF = int'(ADDR_RXFLAG);
    localparam int ADDR_RI = int'(ADDR_RXIE);

    logic            wr_tx, wr_rf, wr_ri;
    logic [NBUF-1:0] clr_empty, clr_ack;
    logic [NBUF-1:0] empty_q, ack_q;
    rx_state_t       rx_d, rx_q;

    assign wr_tx = cpu_wr_i && (int'(cpu_addr_i) == ADDR_TX);
    assign wr_rf = cpu_wr_i && (int'(cpu_addr_i) == ADDR_RF);
    assign wr_ri = cpu_wr_i && (int'(cpu_addr_i) == ADDR_RI);

    for (genvar b = 0; b < NBUF; b++) begin : g_slot
        assign clr_empty[b] = wr_tx & cpu_wdata_i[TXF_EMPTY_LSB + b];
        assign clr_ack[b]   = wr_tx & cpu_wdata_i[TXF_ACK_LSB + b];
        cantx_flag_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .soft_i      (soft_rst_i),
            .sent_i      (tx_sent_i[b]),
            .abort_i     (tx_aborted_i[b]),
            .clr_empty_i (clr_empty[b]),
            .clr_ack_i   (clr_ack[b]),
            .empty_o     (empty_q[b]),
            .ack_o       (ack_q[b])
        );
    end

    always_comb begin
        rx_d = rx_q;
        if (soft_rst_i) begin
            rx_d.rx_full = 1'b0;
            rx_d.rx_ie   = 1'b0;
        end else begin
            rx_d.rx_full = rx_done_i | (rx_q.rx_full & ~(wr_rf & cpu_wdata_i[0]));
            if (wr_ri)
                rx_d.rx_ie = cpu_wdata_i[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q.rx_full <= 1'b0;
            rx_q.rx_ie   <= 1'b0;
        end else begin
            rx_q <= rx_d;
        end
    end

    always_comb begin
        cpu_rdata_o = '0;
        case (int'(cpu_addr_i))
            ADDR_TX: begin
                for (int b = 0; b < NBUF; b++) begin
                    cpu_rdata_o[TXF_EMPTY_LSB + b] = empty_q[b];
                    cpu_rdata_o[TXF_ACK_LSB + b]   = ack_q[b];
                end
            end
            ADDR_RF: cpu_rdata_o[0] = rx_q.rx_full;
            ADDR_RI: cpu_rdata_o[0] = rx_q.rx_ie;
            default: cpu_rdata_o = '0;
        endcase
    end

    cantx_irq_merge #(.NBUF(NBUF)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .empty_i    (empty_q),
        .ack_i      (ack_q),
        .empty_ie_i (empty_ie_i),
        .ack_ie_i   (abort_ie_i),
        .rx_full_i  (rx_q.rx_full),
        .rx_ie_i    (rx_q.rx_ie),
        .tx_irq_o   (tx_irq_o),
        .rx_irq_o   (rx_irq_o)
    );

    // R9
    soft_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (!rx_q.rx_ie && !rx_q.rx_full && (empty_q == '1) && (ack_q == '0)));
    // R8
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_i && !soft_rst_i) |=> rx_q.rx_full);
endmodule

// File: tb/cantx_flag_unit_test.sv
module cantx_flag_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst_i = 1'b0;
    logic [1:0] cpu_addr_i = '0;
    logic       cpu_wr_i = 1'b0;
    logic [7:0] cpu_wdata_i = '0;
    logic [7:0] cpu_rdata_o;
    logic [2:0] tx_sent_i = '0, tx_aborted_i = '0, empty_ie_i = '0, abort_ie_i = '0;
    logic       rx_done_i = 1'b0;
    logic       tx_irq_o, rx_irq_o;

    int total = 0, bad = 0, cycles = 0;
    string phase = "R1";

    bit [2:0] m_empty = 3'b111, m_ack = 3'b000;
    bit m_rxf = 0, m_rxie = 0, m_txirq = 0, m_rxirq = 0;

    always #10 clk = ~clk;

    cantx_flag_unit uut (.*);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_empty = 3'b111; m_ack = 0; m_rxf = 0; m_rxie = 0; m_txirq = 0; m_rxirq = 0;
        end else begin
            m_txirq = ((m_empty & empty_ie_i) != 0) || ((m_ack & abort_ie_i) != 0);
            m_rxirq = m_rxf && m_rxie;
            if (soft_rst_i) begin
                m_empty = 3'b111; m_ack = 0; m_rxf = 0; m_rxie = 0;
            end else begin
                for (int i = 0; i < 3; i++) begin
                    bit ce, ca;
                    ce = cpu_wr_i && cpu_addr_i == 0 && cpu_wdata_i[i];
                    ca = cpu_wr_i && cpu_addr_i == 0 && cpu_wdata_i[4+i];
                    if (tx_sent_i[i] || tx_aborted_i[i]) m_empty[i] = 1;
                    else if (ce) m_empty[i] = 0;
                    if (!m_empty[i]) m_ack[i] = 0;
                    else if (tx_aborted_i[i]) m_ack[i] = 1;
                    else if (ca) m_ack[i] = 0;
                end
                if (rx_done_i) m_rxf = 1;
                else if (cpu_wr_i && cpu_addr_i == 1 && cpu_wdata_i[0]) m_rxf = 0;
                if (cpu_wr_i && cpu_addr_i == 2) m_rxie = cpu_wdata_i[0];
            end
        end
    end

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return {1'b0, m_ack, 1'b0, m_empty};
            2'd1: return {7'b0, m_rxf};
            2'd2: return {7'b0, m_rxie};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(phase, cpu_rdata_o, m_read(cpu_addr_i));
            chk({phase, " R7 tx_irq"}, {7'b0, tx_irq_o}, {7'b0, m_txirq});
            chk({phase, " R8 rx_irq"}, {7'b0, rx_irq_o}, {7'b0, m_rxirq});
        end
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(input logic wr = 0, input logic [1:0] a = 0, input logic [7:0] d = 0,
                        input logic [2:0] s = 0, input logic [2:0] ab = 0, input logic rx = 0);
        cpu_wr_i = wr; cpu_addr_i = a; cpu_wdata_i = d;
        tx_sent_i = s; tx_aborted_i = ab; rx_done_i = rx;
        @(posedge clk); #1;
        cpu_wr_i = 0; tx_sent_i = 0; tx_aborted_i = 0; rx_done_i = 0;
    endtask

    task automatic rd(input logic [1:0] a, input string req, input logic [7:0] exp);
        cpu_addr_i = a;
        @(negedge clk);
        chk(req, cpu_rdata_o, exp);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        rd(0, "R1 flags", 8'h07);
        rd(1, "R1 rx flag", 8'h00);
        rd(2, "R1 rx ie", 8'h00);
        rd(3, "R10 addr3", 8'h00);
        chk("R1 irqs", {6'b0, tx_irq_o, rx_irq_o}, 8'h00);
        phase = "R2";
        step(1, 0, 8'h00); rd(0, "R2 write zero", 8'h07);
        step(1, 0, 8'h01); rd(0, "R2 clear one", 8'h06);
        step(1, 0, 8'h06); rd(0, "R2 clear rest", 8'h00);
        phase = "R3";
        step(0, 0, 0, 3'b001); rd(0, "R3 sent", 8'h01);
        phase = "R4";
        step(0, 0, 0, 0, 3'b010); rd(0, "R4 aborted", 8'h23);
        phase = "R5";
        step(1, 0, 8'h02); rd(0, "R5 ack auto clear", 8'h01);
        step(0, 0, 0, 0, 3'b100); rd(0, "R5 abort2", 8'h45);
        step(1, 0, 8'h40); rd(0, "R5 ack w1c", 8'h05);
        phase = "R6";
        step(1, 0, 8'h01, 3'b001); rd(0, "R6 sent beats clear", 8'h05);
        step(1, 0, 8'h12, 0, 3'b010); rd(0, "R6 abort beats clear", 8'h27);
        phase = "R7";
        step(1, 0, 8'h27); rd(0, "R7 all clear", 8'h00);
        empty_ie_i = 3'b010;
        @(negedge clk); chk("R7 no flag", {7'b0, tx_irq_o}, 8'h00);
        step(0, 0, 0, 3'b010);
        @(negedge clk); chk("R7 not yet", {7'b0, tx_irq_o}, 8'h00);
        @(negedge clk); chk("R7 one clock later", {7'b0, tx_irq_o}, 8'h01);
        empty_ie_i = 0; abort_ie_i = 3'b001;
        step(0, 0, 0, 0, 3'b001); @(negedge clk); @(negedge clk);
        chk("R7 abort enable", {7'b0, tx_irq_o}, 8'h01);
        abort_ie_i = 0;
        phase = "R8";
        step(0, 0, 0, 0, 0, 1); @(negedge clk); @(negedge clk);
        chk("R8 no irq when disabled", {7'b0, rx_irq_o}, 8'h00);
        rd(1, "R8 rx full", 8'h01);
        step(1, 2, 8'hFF); rd(2, "R10 ie upper bits", 8'h01);
        @(negedge clk); chk("R8 rx irq", {7'b0, rx_irq_o}, 8'h01);
        step(1, 1, 8'h01); rd(1, "R8 rx w1c", 8'h00);
        phase = "R9";
        step(1, 0, 8'h07);
        soft_rst_i = 1;
        step(1, 2, 8'h01, 0, 0, 1);
        rd(0, "R9 flags held", 8'h07);
        rd(2, "R9 ie held", 8'h00);
        rd(1, "R9 rx held", 8'h00);
        soft_rst_i = 0;
        phase = "mixed R2-model";
        for (int n = 0; n < 600; n++) begin
            empty_ie_i = 3'($urandom); abort_ie_i = 3'($urandom);
            soft_rst_i = ($urandom % 40) == 0;
            step($urandom % 2 == 0, 2'($urandom), 8'($urandom),
                 ($urandom % 3 == 0) ? 3'($urandom) : 3'b0,
                 ($urandom % 4 == 0) ? 3'($urandom) : 3'b0, $urandom % 5 == 0);
        end
        soft_rst_i = 0;
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule